// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block watches the transmit enable of an Ethernet MAC-to-PHY path and stops a transmitter that will not let go of the line. It counts how many clock cycles transmit enable has been held high without a break. When that run reaches a limit, the block enters a jabber state. In that state it blocks the transmit output and drives a collision indication back to the MAC.

The jabber state ends only after transmit enable has stayed low for a full quiet interval. Any transmit attempt during that interval starts the quiet count again. A sticky flag records that a jabber event took place and is cleared by a read strobe. A guard enable input turns the watchdog on, for example only in 10 Mb/s operation. Both intervals are parameters counted in clock cycles. The defaults give about 100 ms and 500 ms at 125 MHz, and small values keep simulation short.

Top module: `tx_jabber_guard`

## Requirements
- R1: While rst_n is low, col_jabber and jabber_seen are 0. After reset the block is in the armed (not jabbed) state with both counters cleared.
- R2: With guard_en high, the block enters jabber at the rising edge that samples tx_en high for the TRIP_CYCLES-th consecutive cycle. From that edge on, col_jabber is 1 and tx_gate is 0.
- R3: A run of TRIP_CYCLES-1 or fewer high cycles followed by one low cycle does not trip the block. The next run counts again from zero.
- R4: While jabbed, tx_gate stays 0 and col_jabber stays 1 whatever the value of tx_en.
- R5: The jabber state ends at the edge that samples tx_en low for the UNJAB_CYCLES-th consecutive cycle, after which col_jabber is 0. Any cycle with tx_en high during the quiet interval restarts the count from zero.
- R6: jabber_seen is set at the edge where jabber begins and stays set after the jabber state ends. It clears at an edge that samples status_rd high. If a jabber begins at the same edge as a read, the set wins.
- R7: With guard_en low, no timing takes place, tx_gate equals tx_en, and a jabber state in progress ends at the next edge with both counters cleared.
- R8: Outside the jabber state, tx_gate equals tx_en in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| guard_en | input | 1 | Turns the watchdog on (speed/mode select) |
| status_rd | input | 1 | Read strobe that clears the sticky flag |
| tx_gate | output | 1 | Transmit enable passed on to the line side |
| col_jabber | output | 1 | Collision indication to the MAC while jabbed |
| jabber_seen | output | 1 | Sticky record that a jabber occurred |

## Verification
The bench builds the block with TRIP_CYCLES = 8 and UNJAB_CYCLES = 12. With these values, the exact trip edge and the cycle just before it can both be reached in a few cycles. So can the release edge and the quiet-count restart. The small values also allow runs that fall one cycle short of each limit, a read that lands on a trip edge, and turning the guard off while jabbed.

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
  parameter int unsigned TRIP_CYCLES  = 12_500_000,
  parameter int unsigned UNJAB_CYCLES = 62_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic guard_en,
  input  logic status_rd,
  output logic tx_gate,
  output logic col_jabber,
  output logic jabber_seen
);
  localparam int TW = $clog2(TRIP_CYCLES + 1);
  localparam int QW = $clog2(UNJAB_CYCLES + 1);

  logic          jabbing;
  logic [TW-1:0] run_cnt;
  logic [QW-1:0] quiet_cnt;

  wire run_full   = (run_cnt == TW'(TRIP_CYCLES - 1));
  wire quiet_full = (quiet_cnt == QW'(UNJAB_CYCLES - 1));
  wire trip       = guard_en && !jabbing && tx_en && run_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jabbing   <= 1'b0;
      run_cnt   <= '0;
      quiet_cnt <= '0;
    end else if (!guard_en) begin
      jabbing   <= 1'b0;
      run_cnt   <= '0;
      quiet_cnt <= '0;
    end else if (jabbing) begin
      run_cnt <= '0;
      if (tx_en) begin
        quiet_cnt <= '0;
      end else if (quiet_full) begin
        jabbing   <= 1'b0;
        quiet_cnt <= '0;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end else begin
      quiet_cnt <= '0;
      if (!tx_en) begin
        run_cnt <= '0;
      end else if (run_full) begin
        jabbing <= 1'b1;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         jabber_seen <= 1'b0;
    else if (trip)      jabber_seen <= 1'b1;
    else if (status_rd) jabber_seen <= 1'b0;
  end

  assign tx_gate    = tx_en & ~jabbing;
  assign col_jabber = jabbing;

  // R2
  trip_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_jabber) |-> ($past(tx_en) && $past(guard_en)));

  // R4
  gate_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_jabber |-> !tx_gate);

  // R5
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_jabber) |-> (!$past(tx_en) || !$past(guard_en)));

  // R3
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt < TW'(TRIP_CYCLES)) && (quiet_cnt < QW'(UNJAB_CYCLES)));

  // R6
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_jabber) |-> jabber_seen);

  // R6
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jabber_seen) |-> $past(status_rd));

  // R7
  guard_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(guard_en) |-> !col_jabber);
endmodule

// File: tb/test_tx_jabber_guard.sv
module test_tx_jabber_guard;
  localparam int unsigned TRIP  = 8;
  localparam int unsigned UNJAB = 12;

  typedef struct {
    bit    g;
    bit    c;
    bit    s;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic guard_en = 1'b1;
  logic status_rd = 1'b0;
  logic tx_gate, col_jabber, jabber_seen;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  tx_jabber_guard #(.TRIP_CYCLES(TRIP), .UNJAB_CYCLES(UNJAB)) i_tx_jabber_guard (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .guard_en(guard_en),
    .status_rd(status_rd), .tx_gate(tx_gate), .col_jabber(col_jabber),
    .jabber_seen(jabber_seen)
  );

  task automatic seg(input int n, input bit tx, input bit en, input bit rd,
                     input bit g, input bit c, input bit s, input string req);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      tx_en = tx; guard_en = en; status_rd = rd;
      e.g = g; e.c = c; e.s = s; e.req = req;
      q.push_back(e);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (tx_gate !== e.g || col_jabber !== e.c || jabber_seen !== e.s) begin
        fails++;
        $display("FAIL %s: got gate=%b col=%b seen=%b expected gate=%b col=%b seen=%b",
                 e.req, tx_gate, col_jabber, jabber_seen, e.g, e.c, e.s);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (col_jabber !== 1'b0 || jabber_seen !== 1'b0) begin
      fails++;
      $display("FAIL R1: got col=%b seen=%b expected col=0 seen=0", col_jabber, jabber_seen);
    end
    rst_n = 1'b1;
    seg(3, 0, 1, 0, 0, 0, 0, "R1 idle after reset");
    seg(TRIP - 1, 1, 1, 0, 1, 0, 0, "R8 short burst passes");
    seg(1, 0, 1, 0, 0, 0, 0, "R3 gap below limit");
    seg(TRIP - 1, 1, 1, 0, 1, 0, 0, "R3 count restarted");
    seg(1, 0, 1, 0, 0, 0, 0, "R3 second gap");
    seg(TRIP - 1, 1, 1, 0, 1, 0, 0, "R2 before trip edge");
    seg(1, 1, 1, 0, 0, 1, 1, "R2 trip edge");
    seg(3, 1, 1, 0, 0, 1, 1, "R4 held while jabbed");
    seg(UNJAB - 1, 0, 1, 0, 0, 1, 1, "R5 quiet short of limit");
    seg(1, 1, 1, 0, 0, 1, 1, "R4 tx during quiet");
    seg(UNJAB - 1, 0, 1, 0, 0, 1, 1, "R5 quiet count restarted");
    seg(1, 0, 1, 0, 0, 0, 1, "R5 release edge");
    seg(2, 1, 1, 0, 1, 0, 1, "R6 sticky after release");
    seg(1, 0, 1, 1, 0, 0, 0, "R6 cleared by read");
    seg(20, 1, 0, 0, 1, 0, 0, "R7 guard off no trip");
    seg(TRIP - 1, 1, 1, 0, 1, 0, 0, "R7 counting from zero");
    seg(1, 1, 1, 1, 0, 1, 1, "R6 set wins over read");
    seg(1, 1, 0, 0, 1, 0, 1, "R7 guard off ends jabber");
    seg(1, 0, 0, 0, 0, 0, 1, "R8 gate follows tx");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule